// File: doc/BRIEF.md
# Chained Indexed Indirect Address Resolver

This block turns an instruction's address word into a final effective address. Each word it handles holds three fields: an address, an index-register selector and an indirect flag. The selector may name one of fifteen index registers, and that register's value is added to the address field. If the indirect flag is set, the resulting address is read from memory, and the fetched word is treated the same way, with its own selector and its own flag. Each level of the chain can therefore be indexed by a different register. The chain ends at the first word whose indirect flag is clear.

A caller pulses `start_i` with the first word. The block reads index registers through a combinational port (`xsel_o` out, `xval_i` back in the same cycle). It fetches indirect words through a request/acknowledge read port, and ends with a one-cycle `done_o` and the address on `ea_o`. If a chain would need more than `MAX_LEVELS` memory fetches, the block gives up and pulses `err_o` instead, so a self-referencing chain cannot lock it up.

The controller has five named states:
- IDLE waits for a start.
- CALC forms the address for the current word.
- FETCH holds a memory read open until it is acknowledged.
- DONE delivers the result.
- FAIL reports an overlong chain.

The transitions are:
- IDLE→CALC on start.
- CALC→DONE when the flag is clear.
- CALC→FETCH when the flag is set and the fetch budget remains.
- CALC→FAIL when the flag is set and the budget is spent.
- FETCH→CALC on acknowledge.
- DONE→IDLE and FAIL→IDLE unconditionally.

Top module: `ea_chain`

## Requirements
- R1: After reset the block is idle: `busy_o`, `mreq_o`, `done_o` and `err_o` are all low.
- R2: Word layout: bits 17:0 hold the address field, bits 21:18 the index selector, and bit 22 the indirect flag. A selector of 0 adds nothing, so a word with a clear flag and a zero selector yields its own address field.
- R3: A nonzero selector adds the low 18 bits of the named register to the address field, modulo 2^18. Register bits 35:18 have no effect.
- R4: For each set indirect flag, the block raises `mreq_o` with the formed address on `maddr_o` and holds both steady until `mack_i`. `mdata_i` is sampled in the acknowledge cycle, and exactly one fetch is made per indirect level.
- R5: Each fetched word is evaluated with its own selector and flag, so successive levels may use different index registers.
- R6: The first word with a clear flag ends the chain. `done_o` pulses and `ea_o` holds the address formed from that word.
- R7: A chain that ends within `MAX_LEVELS` (64) fetches completes normally. A chain that would need fetch number 65 pulses `err_o` and does not pulse `done_o`.
- R8: `done_o` and `err_o` are each high for exactly one cycle per calculation and never together.
- R9: `start_i` is ignored while a calculation is in progress. The result is that of the original word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a calculation (sampled when idle) |
| word_i | input | 36 | Initial address word |
| xsel_o | output | 4 | Index register selector for the register read port |
| xval_i | input | 36 | Contents of the selected register (combinational) |
| mreq_o | output | 1 | Memory read request, held until acknowledged |
| maddr_o | output | 18 | Memory read address |
| mack_i | input | 1 | Memory read acknowledge; data valid this cycle |
| mdata_i | input | 36 | Memory read data |
| busy_o | output | 1 | Calculation in progress |
| done_o | output | 1 | One-cycle strobe: `ea_o` is valid |
| err_o | output | 1 | One-cycle strobe: chain exceeded the fetch limit |
| ea_o | output | 18 | Effective address |

## Verification
The hardest situation to reach is the fetch-limit boundary. A chain must run exactly 64 fetches and end cleanly, and its twin must demand a 65th fetch. Random memory contents almost never produce chains that long. The stimulus therefore writes a directed ladder into the modelled memory, with each word pointing to the next, and builds both the 64-fetch and 65-fetch variants. A word pointing at itself is added as well. Random chains, with random register contents whose upper halves are garbage and random acknowledge delays, cover the indexing and wrap behaviour around these directed cases.

// File: rtl/ea_pkg.sv
package ea_pkg;
    localparam int WORD_W = 36;
    localparam int ADDR_W = 18;
    localparam int SEL_W  = 4;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CALC,
        S_FETCH,
        S_DONE,
        S_FAIL
    } ea_state_t;
endpackage

// File: rtl/ea_index_add.sv
module ea_index_add #(
    parameter int ADDR_W = 18,
    parameter int SEL_W  = 4,
    parameter int WORD_W = 36
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [WORD_W-1:0] xval_i,
    output logic [ADDR_W-1:0] sum_o
);
    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset = (sel_i == '0) ? '0 : xval_i[ADDR_W-1:0];
        sum_o  = base_i + offset;
    end
endmodule

// File: rtl/ea_depth_ctr.sv
module ea_depth_ctr #(
    parameter int MAX_LEVELS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic limit_o
);
    localparam int CNT_W = $clog2(MAX_LEVELS + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_LEVELS);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr_i)
            cnt <= '0;
        else if (inc_i && cnt != CNT_MAX)
            cnt <= cnt + 1'b1;
    end

    assign limit_o = (cnt == CNT_MAX);

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_MAX);
    p_no_inc_at_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (limit_o && !clr_i) |=> limit_o);
endmodule

// File: rtl/ea_chain.sv
module ea_chain
    import ea_pkg::*;
#(
    parameter int MAX_LEVELS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [SEL_W-1:0]  xsel_o,
    input  logic [WORD_W-1:0] xval_i,
    output logic              mreq_o,
    output logic [ADDR_W-1:0] maddr_o,
    input  logic              mack_i,
    input  logic [WORD_W-1:0] mdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [ADDR_W-1:0] ea_o
);
    localparam int SEL_LO  = ADDR_W;
    localparam int IND_POS = ADDR_W + SEL_W;

    ea_state_t         state, nxt;
    logic [WORD_W-1:0] cur;
    logic [ADDR_W-1:0] maddr_q, ea_q, formed;
    logic              ind, limit, go_fetch, cnt_clr;

    assign ind      = cur[IND_POS];
    assign xsel_o   = cur[SEL_LO +: SEL_W];
    assign go_fetch = (state == S_CALC) && ind && !limit;
    assign cnt_clr  = (state == S_IDLE) && start_i;

    ea_index_add #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .WORD_W(WORD_W)) u_add (
        .base_i (cur[ADDR_W-1:0]),
        .sel_i  (xsel_o),
        .xval_i (xval_i),
        .sum_o  (formed)
    );

    ea_depth_ctr #(.MAX_LEVELS(MAX_LEVELS)) u_depth (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (cnt_clr),
        .inc_i   (go_fetch),
        .limit_o (limit)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur     <= '0;
            maddr_q <= '0;
            ea_q    <= '0;
        end else begin
            if (cnt_clr)
                cur <= word_i;
            if (state == S_FETCH && mack_i)
                cur <= mdata_i;
            if (go_fetch)
                maddr_q <= formed;
            if (state == S_CALC && !ind)
                ea_q <= formed;
        end
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (start_i) nxt = S_CALC;
            S_CALC: begin
                if (!ind)       nxt = S_DONE;
                else if (limit) nxt = S_FAIL;
                else            nxt = S_FETCH;
            end
            S_FETCH: if (mack_i) nxt = S_CALC;
            S_DONE:  nxt = S_IDLE;
            S_FAIL:  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy_o  = (state != S_IDLE);
        mreq_o  = (state == S_FETCH);
        done_o  = (state == S_DONE);
        err_o   = (state == S_FAIL);
        maddr_o = maddr_q;
        ea_o    = ea_q;
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mreq_o && !done_o && !err_o));
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq_o && !mack_i) |=> (mreq_o && $stable(maddr_o)));
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || err_o) |=> (!done_o && !err_o));
    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !err_o);
    p_fail_at_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> $past(limit));
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FETCH && !mack_i && start_i) |=> (state == S_FETCH && $stable(cur)));
endmodule

// File: tb/sim_ea_chain.sv
module sim_ea_chain;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [35:0] word_i = '0;
    logic [3:0]  xsel_o;
    logic [35:0] xval_i;
    logic        mreq_o;
    logic [17:0] maddr_o;
    logic        mack_i = 1'b0;
    logic [35:0] mdata_i = '0;
    logic        busy_o, done_o, err_o;
    logic [17:0] ea_o;

    logic [35:0] regs [0:15];
    logic [35:0] mem  [0:255];
    int          checks = 0, fails = 0, nfetch = 0, dly = 0;

    always #4 clk = ~clk;

    assign xval_i = regs[xsel_o];

    ea_chain u0 (.*);

    // Memory responder with random acknowledge delay
    always @(negedge clk) begin
        if (mreq_o && !mack_i) begin
            if (dly == 0) begin
                mack_i  <= 1'b1;
                mdata_i <= mem[maddr_o[7:0]];
                nfetch  <= nfetch + 1;
            end else dly <= dly - 1;
        end else begin
            mack_i <= 1'b0;
            dly    <= int'($urandom % 3);
        end
    end

    function automatic logic [35:0] mk(bit ind, logic [3:0] sel, logic [17:0] a);
        return {13'd0, ind, sel, a};
    endfunction

    // Reference model: walk chain, return EA, error flag and fetch count
    function automatic void model(input logic [35:0] w, output logic [17:0] ea,
                                  output bit er, output int nf);
        logic [35:0] c = w;
        logic [17:0] a;
        nf = 0; er = 0; ea = '0;
        for (int i = 0; i < 200; i++) begin
            a = c[17:0] + ((c[21:18] == 0) ? 18'd0 : regs[c[21:18]][17:0]);
            if (!c[22]) begin ea = a; return; end
            if (nf == 64) begin er = 1; return; end
            nf++;
            c = mem[a[7:0]];
        end
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run(logic [35:0] w, string req, bit poke);
        logic [17:0] eea; bit eer; int enf; int t = 0;
        model(w, eea, eer, enf);
        @(negedge clk);
        nfetch  = 0;
        start_i = 1'b1; word_i = w;
        @(negedge clk);
        start_i = 1'b0; word_i = '0;
        while (!done_o && !err_o && t < 2000) begin
            if (poke && busy_o && !done_o && !err_o) begin
                start_i = 1'b1; word_i = mk(0, 0, 18'h2AAAA);
            end
            @(negedge clk);
            start_i = 1'b0;
            t++;
        end
        chk(t < 2000, req, "completion (watchdog)", t, 0);
        chk(err_o == eer, req, "err_o", err_o, eer);
        chk(done_o == !eer, req, "done_o", done_o, !eer);
        if (!eer) chk(ea_o == eea, req, "ea_o", ea_o, eea);
        chk(nfetch == enf, "R4", "fetch count", nfetch, enf);
        @(negedge clk);
        chk(!done_o && !err_o, "R8", "strobe width", {done_o, err_o}, 0);
        chk(!busy_o, "R8", "back to idle", busy_o, 0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 16; i++) regs[i] = {$urandom, $urandom} & 36'hF_FFFF_FFFF;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        chk(!busy_o && !mreq_o && !done_o && !err_o, "R1", "reset outputs",
            {busy_o, mreq_o, done_o, err_o}, 0);
        rst_n = 1'b1;

        // R2: plain address, no index
        run(mk(0, 0, 18'h1_2345), "R2", 0);
        // R3: wrap modulo 2^18, garbage upper register bits
        regs[2] = 36'hF_FFFC_0002;
        run(mk(0, 2, 18'h3_FFFF), "R3", 0);
        // R5: three levels, three registers
        regs[1] = 36'd5; regs[3] = 36'd100; regs[4] = 36'h3_FFF0;
        mem[15]  = mk(1, 3, 18'd3);
        mem[103] = mk(0, 4, 18'h20);
        run(mk(1, 1, 18'd10), "R5", 0);
        // R6: indirect word with clear flag ends chain
        mem[40] = mk(0, 0, 18'h0_BEEF);
        run(mk(1, 0, 18'd40), "R6", 0);
        // R9: start pulses while busy are ignored
        run(mk(1, 1, 18'd10), "R9", 1);
        // R7: exactly 64 fetches completes
        for (int i = 0; i < 63; i++) mem[i] = mk(1, 0, 18'(i + 1));
        mem[63] = mk(0, 0, 18'h3_ABCD);
        run(mk(1, 0, 18'd0), "R7", 0);
        // R7: 65 fetches needed -> error
        mem[63] = mk(1, 0, 18'd64);
        mem[64] = mk(0, 0, 18'h1_1111);
        run(mk(1, 0, 18'd0), "R7", 0);
        // R7: self loop
        mem[200] = mk(1, 0, 18'd200);
        run(mk(1, 0, 18'd200), "R7", 0);

        // Random chains (R3, R5, R6)
        for (int n = 0; n < 60; n++) begin
            for (int i = 0; i < 16; i++) regs[i] = {$urandom, $urandom} & 36'hF_FFFF_FFFF;
            for (int i = 0; i < 256; i++)
                mem[i] = {$urandom, $urandom} & 36'h0_007F_FFFF
                         & (($urandom % 3 == 0) ? 36'hF_FFFF_FFFF : 36'hF_FFBF_FFFF);
            run({$urandom, $urandom} & 36'h0_007F_FFFF, "R5", 0);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(8 * 150000);
        fails++; checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule